// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block sits in the feedback path of a synthesizer. It counts ticks of a gated RF clock, shown as one-cycle `rfEn` strobes on the system clock. It emits one pulse toward the phase detector at the end of each feedback period. Over many periods the average period length is INT + FRAC/MOD ticks.

A third-order noise-shaping modulator decides the length of each period. It is built as three cascaded accumulators that wrap at a programmable modulus, which need not be a power of two. The modulator steps once per period and adds a small offset to INT. A dual-modulus prescaler model then realises each integer divisor from a prescaler value P, a main count B and a swallow count A, with N = P*B + A. It picks P = 4 (4/5 mode) or P = 8 (8/9 mode) from the divisor itself.

Software programs INT, FRAC and MOD through a small write port. A write whose value is out of range is dropped and raises an error strobe. A new value reaches the counters only at a period boundary.

Top module: `fracn_divider`

## Requirements
- R1: After reset, INT=26, FRAC=0 and MOD=2, and `fbPulse` and `wrErr` are low. Each period then lasts exactly 26 ticks with `presc8` low.
- R2: A write to address 0 sets INT and is accepted only for values 26 to 255. Any other value is rejected: INT keeps its old value and `wrErr` is high in the clock cycle after the write cycle.
- R3: A write to address 1 sets FRAC and is accepted only when the value is below the current MOD. A write to address 2 sets MOD and is accepted only when the value is at least 2 and above the current FRAC. A rejected write changes nothing and raises `wrErr` as in R2.
- R4: A write to address 3 is always rejected and raises `wrErr`.
- R5: With FRAC=0, every period lasts exactly INT ticks.
- R6: Every period lasts between INT-3 and INT+4 ticks.
- R7: Take J periods counted from the first boundary after an accepted FRAC or MOD write. Their total tick count minus J*INT minus floor((J-1)*FRAC/MOD) lies between -1 and +2.
- R8: Each period lasts P*B+A ticks, equal to the divisor shown on `curDiv`. P is 8 (`presc8` high) when that divisor exceeds 80 and 4 otherwise. `curDiv` and `presc8` describe the running period from the cycle after its start boundary.
- R9: A register write does not change the length of the period in progress. It takes effect at the next period boundary.
- R10: Only cycles with `rfEn` high advance the count. `fbPulse` is high for exactly one cycle, the cycle after the edge that took the last tick of a period.
- R11: An accepted FRAC or MOD write restarts the modulator, so the first period that starts after it lasts exactly INT ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rfEn | input | 1 | One RF tick to count in this cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 INT, 1 FRAC, 2 MOD, 3 unused |
| wrData | input | 12 | Write value |
| fbPulse | output | 1 | One-cycle pulse at the end of each feedback period |
| curDiv | output | 9 | Integer divisor of the period now running |
| presc8 | output | 1 | High when the running period uses the 8/9 prescaler |
| wrErr | output | 1 | High for one cycle after a rejected write |

## Verification
The hardest situation to reach is a run of modulator offsets that carries the instantaneous divisor across the prescaler threshold, or down to INT-3 at the lowest INT. Only particular FRAC/MOD pairs near those edges produce such a run. The bench programs INT values of 26, 80 and 255 with FRAC close to MOD, and sweeps every FRAC for one small MOD. Each sweep starts from a freshly cleared modulator, so the cumulative tick count can be bounded arithmetically. Some runs gate `rfEn` with a pseudo-random pattern, so that counting holds across idle cycles.

// File: rtl/fracn_pkg.sv
`timescale 1ns/1ps
package fracn_pkg;
  localparam int DIV_W      = 9;               // divisor up to INT max plus dither
  localparam int PRE_LO_LOG = 2;               // 4/5 prescaler
  localparam int PRE_HI_LOG = PRE_LO_LOG + 1;  // 8/9 prescaler
  localparam int MAIN_W     = DIV_W - PRE_LO_LOG;
  localparam int SW_W       = PRE_HI_LOG;

  typedef enum logic [1:0] {
    ADDR_INT  = 2'd0,
    ADDR_FRAC = 2'd1,
    ADDR_MOD  = 2'd2,
    ADDR_NONE = 2'd3
  } regAddr_t;

  // control -> datapath: settings for the next period
  typedef struct packed {
    logic [DIV_W-1:0]  divisor;
    logic              presc8;
    logic [MAIN_W-1:0] mainCnt;
    logic [SW_W-1:0]   swallow;
  } loadCfg_t;
endpackage

// File: rtl/fracn_ctrl.sv
`timescale 1ns/1ps
module fracn_ctrl
  import fracn_pkg::*;
#(
  parameter int MOD_W        = 12,
  parameter int INT_MIN      = 26,
  parameter int INT_MAX      = 255,
  parameter int PRESC_THRESH = 80
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [MOD_W-1:0] wrData,
  input  logic             take,
  output loadCfg_t         cfg,
  output logic             wrErr
);
  localparam int INT_W  = $clog2(INT_MAX + 1);
  localparam int SUM_W  = MOD_W + 1;
  localparam int STAGES = 3;
  localparam logic [MOD_W-1:0] INT_LO  = MOD_W'(INT_MIN);
  localparam logic [MOD_W-1:0] INT_HI  = MOD_W'(INT_MAX);
  localparam logic [MOD_W-1:0] MOD_LO  = MOD_W'(2);
  localparam logic [DIV_W-1:0] THRESH  = DIV_W'(PRESC_THRESH);

  logic [INT_W-1:0] intReg;
  logic [MOD_W-1:0] fracReg, modReg;
  logic [MOD_W-1:0] accQ [STAGES];
  logic [MOD_W-1:0] accD [STAGES];
  logic [STAGES-1:0] carry;
  logic c2Dly, c3Dly, c3Dly2;
  logic signed [3:0] yReg, yNext;
  logic writeOk, clearMod;
  logic signed [DIV_W:0] nextN;

  // write validation
  always_comb begin
    unique case (regAddr_t'(wrAddr))
      ADDR_INT:  writeOk = (wrData >= INT_LO) && (wrData <= INT_HI);
      ADDR_FRAC: writeOk = (wrData < modReg);
      ADDR_MOD:  writeOk = (wrData >= MOD_LO) && (wrData > fracReg);
      default:   writeOk = 1'b0;
    endcase
  end
  assign clearMod = wrEn && writeOk &&
                    ((regAddr_t'(wrAddr) == ADDR_FRAC) || (regAddr_t'(wrAddr) == ADDR_MOD));

  // cascade of accumulators wrapping at modReg
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [MOD_W-1:0] inc;
    logic [SUM_W-1:0] sum;
    if (s == 0) begin : g_first
      assign inc = fracReg;
    end else begin : g_chain
      assign inc = accD[s-1];
    end
    assign sum      = {1'b0, accQ[s]} + {1'b0, inc};
    assign carry[s] = sum >= {1'b0, modReg};
    assign accD[s]  = carry[s] ? MOD_W'(sum - {1'b0, modReg}) : sum[MOD_W-1:0];
  end

  // noise-shaped recombination of the three carries
  always_comb begin
    yNext = 4'(carry[0]) + 4'(carry[1]) - 4'(c2Dly) + 4'(carry[2])
          - 4'({c3Dly, 1'b0}) + 4'(c3Dly2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intReg  <= INT_W'(INT_MIN);
      fracReg <= '0;
      modReg  <= MOD_LO;
      wrErr   <= 1'b0;
      for (int s = 0; s < STAGES; s++) accQ[s] <= '0;
      c2Dly   <= 1'b0;
      c3Dly   <= 1'b0;
      c3Dly2  <= 1'b0;
      yReg    <= '0;
    end else begin
      wrErr <= wrEn && !writeOk;
      if (wrEn && writeOk) begin
        unique case (regAddr_t'(wrAddr))
          ADDR_INT:  intReg  <= wrData[INT_W-1:0];
          ADDR_FRAC: fracReg <= wrData;
          ADDR_MOD:  modReg  <= wrData;
          default:   ;
        endcase
      end
      if (clearMod) begin
        for (int s = 0; s < STAGES; s++) accQ[s] <= '0;
        c2Dly  <= 1'b0;
        c3Dly  <= 1'b0;
        c3Dly2 <= 1'b0;
        yReg   <= '0;
      end else if (take) begin
        for (int s = 0; s < STAGES; s++) accQ[s] <= accD[s];
        c2Dly  <= carry[1];
        c3Dly  <= carry[2];
        c3Dly2 <= c3Dly;
        yReg   <= yNext;
      end
    end
  end

  // divisor for the next period and its prescaler split
  assign nextN = $signed({{(DIV_W + 1 - INT_W){1'b0}}, intReg}) + (DIV_W + 1)'(yReg);

  always_comb begin
    cfg.divisor = nextN[DIV_W-1:0];
    cfg.presc8  = cfg.divisor > THRESH;
    if (cfg.presc8) begin
      cfg.mainCnt = MAIN_W'(cfg.divisor >> PRE_HI_LOG);
      cfg.swallow = cfg.divisor[PRE_HI_LOG-1:0];
    end else begin
      cfg.mainCnt = MAIN_W'(cfg.divisor >> PRE_LO_LOG);
      cfg.swallow = SW_W'(cfg.divisor[PRE_LO_LOG-1:0]);
    end
  end

  p_offset_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    (yReg >= -4'sd3) && (yReg <= 4'sd4));
  p_int_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (32'(intReg) >= INT_MIN) && (32'(intReg) <= INT_MAX));
  p_frac_below_mod_r3: assert property (@(posedge clk) disable iff (!rstN)
    fracReg < modReg);
  p_acc_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accQ[0] < modReg) && (accQ[1] < modReg) && (accQ[2] < modReg));
  p_err_follows_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> $past(wrEn));
endmodule

// File: rtl/fracn_datapath.sv
`timescale 1ns/1ps
module fracn_datapath
  import fracn_pkg::*;
#(
  parameter int INT_MIN      = 26,
  parameter int INT_MAX      = 255,
  parameter int PRESC_THRESH = 80
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rfEn,
  input  loadCfg_t         cfg,
  output logic             take,
  output logic             fbPulse,
  output logic [DIV_W-1:0] curDiv,
  output logic             presc8
);
  localparam int CNT_W = PRE_HI_LOG + 1;
  localparam logic [CNT_W-1:0] P_LO = CNT_W'(1 << PRE_LO_LOG);
  localparam logic [CNT_W-1:0] P_HI = CNT_W'(1 << PRE_HI_LOG);
  localparam logic [DIV_W-1:0] THRESH = DIV_W'(PRESC_THRESH);

  logic              idle;
  logic [CNT_W-1:0]  presCnt;
  logic [MAIN_W-1:0] mainLeft;
  logic [SW_W-1:0]   swLeft, swNext;
  logic [CNT_W-1:0]  pRun, pLoad;
  logic              cycEnd, lastTick;

  assign cycEnd   = rfEn && !idle && (presCnt == '0);
  assign lastTick = cycEnd && (mainLeft == MAIN_W'(1));
  assign take     = idle || lastTick;
  assign swNext   = (swLeft != '0) ? swLeft - SW_W'(1) : '0;
  assign pRun     = presc8 ? P_HI : P_LO;
  assign pLoad    = cfg.presc8 ? P_HI : P_LO;

  // prescaler cycle lasts P+1 ticks while swallow cycles remain, else P
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idle     <= 1'b1;
      presCnt  <= '0;
      mainLeft <= '0;
      swLeft   <= '0;
      fbPulse  <= 1'b0;
      curDiv   <= '0;
      presc8   <= 1'b0;
    end else begin
      fbPulse <= lastTick;
      if (take) begin
        idle     <= 1'b0;
        curDiv   <= cfg.divisor;
        presc8   <= cfg.presc8;
        mainLeft <= cfg.mainCnt;
        swLeft   <= cfg.swallow;
        presCnt  <= (cfg.swallow != '0) ? pLoad : pLoad - CNT_W'(1);
      end else if (cycEnd) begin
        mainLeft <= mainLeft - MAIN_W'(1);
        swLeft   <= swNext;
        presCnt  <= (swNext != '0) ? pRun : pRun - CNT_W'(1);
      end else if (rfEn && !idle) begin
        presCnt <= presCnt - CNT_W'(1);
      end
    end
  end

  p_swallow_below_main_r8: assert property (@(posedge clk) disable iff (!rstN)
    !idle |-> (32'(swLeft) < 32'(mainLeft)));
  p_presc_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    !idle |-> (presc8 == (curDiv > THRESH)));
  p_div_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    !idle |-> ((32'(curDiv) >= INT_MIN - 3) && (32'(curDiv) <= INT_MAX + 4)));
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    fbPulse |=> !fbPulse);
  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!rfEn && !idle) |=> ($stable(presCnt) && $stable(mainLeft) && !fbPulse));
endmodule

// File: rtl/fracn_divider.sv
`timescale 1ns/1ps
module fracn_divider
  import fracn_pkg::*;
#(
  parameter int MOD_W        = 12,
  parameter int INT_MIN      = 26,
  parameter int INT_MAX      = 255,
  parameter int PRESC_THRESH = 80
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rfEn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [MOD_W-1:0] wrData,
  output logic             fbPulse,
  output logic [DIV_W-1:0] curDiv,
  output logic             presc8,
  output logic             wrErr
);
  loadCfg_t nextCfg;
  logic     take;

  fracn_ctrl #(
    .MOD_W(MOD_W), .INT_MIN(INT_MIN), .INT_MAX(INT_MAX), .PRESC_THRESH(PRESC_THRESH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .take(take), .cfg(nextCfg), .wrErr(wrErr)
  );

  fracn_datapath #(
    .INT_MIN(INT_MIN), .INT_MAX(INT_MAX), .PRESC_THRESH(PRESC_THRESH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rfEn(rfEn), .cfg(nextCfg), .take(take),
    .fbPulse(fbPulse), .curDiv(curDiv), .presc8(presc8)
  );
endmodule

// File: tb/tb_fracn_divider.sv
`timescale 1ns/1ps
module tb_fracn_divider;
  import fracn_pkg::*;
  localparam int MOD_W = 12;

  logic clk = 1'b0, rstN = 1'b0, rfEn = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [MOD_W-1:0] wrData = '0;
  logic fbPulse, presc8, wrErr;
  logic [DIV_W-1:0] curDiv;

  int total = 0, bad = 0, tickCnt = 0, cyc = 0;
  bit gapMode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  fracn_divider #(.MOD_W(MOD_W)) dut (
    .clk(clk), .rstN(rstN), .rfEn(rfEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .fbPulse(fbPulse), .curDiv(curDiv), .presc8(presc8), .wrErr(wrErr)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (rfEn) tickCnt++;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=%0d expected<%0d", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitPulse(output int at, output bit ok);
    int guard = 0;
    ok = 1'b1;
    while (1) begin
      @(negedge clk);
      if (fbPulse) break;
      if (gapMode) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rfEn = lfsr[0] | lfsr[5];
      end else begin
        rfEn = 1'b1;
      end
      guard++;
      if (guard > 3000) begin
        ok = 1'b0;
        chk(1'b0, "R10", "pulse timeout", guard, 0);
        break;
      end
    end
    at = tickCnt;
  endtask

  task automatic wr(input logic [1:0] a, input int d, output bit err);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = MOD_W'(d);
    @(negedge clk);
    wrEn = 1'b0;
    err = wrErr;
  endtask

  task automatic runCfg(input int iv, input int fv, input int mv, input int jn, input bit gap);
    bit e, ok;
    int t0, t, prev, len, expLen, sum, dev;
    @(negedge clk); rfEn = 1'b0;
    wr(ADDR_INT, iv, e);  chk(!e, "R2", "INT write accepted", e, 0);
    wr(ADDR_FRAC, 0, e);  chk(!e, "R3", "FRAC clear accepted", e, 0);
    wr(ADDR_MOD, mv, e);  chk(!e, "R3", "MOD write accepted", e, 0);
    wr(ADDR_FRAC, fv, e); chk(!e, "R3", "FRAC write accepted", e, 0);
    gapMode = gap;
    waitPulse(t0, ok);
    if (!ok) return;
    expLen = int'(curDiv);
    prev = t0; sum = 0;
    for (int j = 1; j <= jn; j++) begin
      waitPulse(t, ok);
      if (!ok) return;
      len = t - prev; prev = t; sum += len;
      chk(len == expLen, "R8", "period equals divisor", len, expLen);
      chk(presc8 == (curDiv > 9'd80), "R8", "prescaler mode", presc8, curDiv > 9'd80);
      chk(len >= iv - 3 && len <= iv + 4, "R6", "period within INT-3..INT+4", len, iv);
      if (j == 1) chk(len == iv, "R11", "first period after restart", len, iv);
      if (fv == 0) chk(len == iv, "R5", "integer period", len, iv);
      expLen = int'(curDiv);
    end
    dev = sum - jn * iv - ((jn - 1) * fv) / mv;
    chk(dev >= -1 && dev <= 2, "R7", "cumulative deviation", dev, 0);
    gapMode = 1'b0;
  endtask

  initial begin
    bit e, ok;
    int t0, t, len, expLen;
    bit p8Next;
    repeat (6) @(negedge clk);
    chk(fbPulse == 1'b0, "R1", "fbPulse low in reset", fbPulse, 0);
    chk(wrErr == 1'b0, "R1", "wrErr low in reset", wrErr, 0);
    rstN = 1'b1;
    waitPulse(t0, ok);
    for (int k = 0; k < 3; k++) begin
      waitPulse(t, ok);
      chk(t - t0 == 26, "R1", "default period", t - t0, 26);
      chk(presc8 == 1'b0, "R1", "default prescaler 4/5", presc8, 0);
      t0 = t;
    end

    // rejected writes (defaults INT=26 FRAC=0 MOD=2)
    @(negedge clk); rfEn = 1'b0;
    wr(ADDR_INT, 25, e);  chk(e, "R2", "INT 25 rejected", e, 1);
    wr(ADDR_INT, 256, e); chk(e, "R2", "INT 256 rejected", e, 1);
    wr(ADDR_FRAC, 2, e);  chk(e, "R3", "FRAC equal MOD rejected", e, 1);
    wr(ADDR_MOD, 1, e);   chk(e, "R3", "MOD 1 rejected", e, 1);
    wr(ADDR_NONE, 5, e);  chk(e, "R4", "address 3 rejected", e, 1);
    wr(ADDR_MOD, 7, e);   chk(!e, "R3", "MOD 7 accepted", e, 0);
    @(negedge clk);
    chk(wrErr == 1'b0, "R2", "error strobe one cycle", wrErr, 0);
    wr(ADDR_FRAC, 9, e);  chk(e, "R3", "FRAC 9 over MOD 7 rejected", e, 1);
    wr(ADDR_FRAC, 3, e);  chk(!e, "R3", "FRAC 3 accepted", e, 0);
    wr(ADDR_MOD, 3, e);   chk(e, "R3", "MOD not above FRAC rejected", e, 1);
    wr(ADDR_FRAC, 0, e);  chk(!e, "R3", "FRAC 0 accepted", e, 0);
    waitPulse(t0, ok);
    for (int k = 0; k < 4; k++) begin
      waitPulse(t, ok);
      chk(t - t0 == 26, "R2", "INT and FRAC unchanged by rejected writes", t - t0, 26);
      t0 = t;
    end

    // sweep every FRAC for a small modulus
    for (int f = 0; f < 7; f++) runCfg(30, f, 7, 15, f[0]);
    // boundary configurations
    runCfg(26, 4, 5, 11, 1'b0);
    runCfg(80, 5, 11, 23, 1'b0);
    runCfg(255, 8, 9, 10, 1'b1);
    runCfg(100, 1, 2, 9, 1'b0);
    runCfg(200, 12, 13, 14, 1'b1);
    runCfg(81, 0, 2, 3, 1'b0);

    // R9: write mid-period takes effect at the next boundary
    runCfg(40, 0, 2, 2, 1'b0);
    waitPulse(t0, ok);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(fbPulse == 1'b0, "R10", "no pulse mid-period", fbPulse, 0);
      rfEn = 1'b1;
    end
    wr(ADDR_INT, 100, e);
    chk(!e, "R9", "INT mid-period accepted", e, 0);
    waitPulse(t, ok);
    chk(t - t0 == 40, "R9", "running period unchanged", t - t0, 40);
    p8Next = presc8; expLen = int'(curDiv); t0 = t;
    chk(p8Next == 1'b1, "R8", "8/9 selected for 100", p8Next, 1);
    waitPulse(t, ok);
    chk(t - t0 == 100, "R9", "new INT at next boundary", t - t0, 100);
    chk(expLen == 100, "R8", "divisor shown", expLen, 100);

    // R10: pulse width and gating hold
    @(negedge clk);
    chk(fbPulse == 1'b0, "R10", "pulse is one cycle", fbPulse, 0);
    t0 = t;
    rfEn = 1'b0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      chk(fbPulse == 1'b0, "R10", "no pulse while gated", fbPulse, 0);
    end
    waitPulse(t, ok);
    len = t - t0;
    chk(len == 100, "R10", "gated cycles not counted", len, 100);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule